// File: doc/BRIEF.md
# CRT Cut-off Measurement Sequencer

This block is the digital timing controller for an automatic black-level loop that serves three colour channels of a CRT drive. It receives a pulse at the start of every line, a level that is high for the whole field retrace, and a comparator flag that reports beam current at the cathode. From these it produces the strobes that the analogue measurement and hold circuits use: a leakage-sample enable, one measurement enable per channel, a reference-line insertion window, and a white-insert request for warm-up.

The leakage current is sampled and held while retrace is high. Then the loop measures one channel per line over the first lines after retrace, in a fixed order: red, then green, then blue. After power-up the loops stay off and white is forced onto the luminance path. This warm-up state ends for good on the first cathode current detection. Only a reset brings it back.

Top module: `cutoff_seq`

## Requirements
- R1: During reset and on the first sample after reset, white_req_o is 1 and leak_smp_o, ref_win_o and every bit of meas_en_o are 0.
- R2: With the loops enabled, leak_smp_o follows retrace_i delayed by one clock. It is therefore high for the whole retrace and low from the clock after retrace ends.
- R3: The first line_start_i pulse sampled with retrace_i low after a retrace sets meas_en_o to 3'b001 (bit 0 is red) from the next clock. It holds that value for the full line, until the clock after the next line_start_i.
- R4: The next two line starts select 3'b010 (bit 1 is green) and then 3'b100 (bit 2 is blue). The line start after that clears meas_en_o to 3'b000, and it stays 0 until a new retrace has occurred.
- R5: At most one bit of meas_en_o is high at any time. No bit of meas_en_o is high while leak_smp_o is high.
- R6: ref_win_o is high exactly while one of the three measurement lines is active with the loops enabled.
- R7: During warm-up, white_req_o is 1 and leak_smp_o, meas_en_o and ref_win_o stay 0 whatever the retrace and line activity.
- R8: The clock after beam_det_i is first sampled high, white_req_o falls to 0 and the loop strobes become active.
- R9: After warm-up has ended, the level of beam_det_i has no effect. white_req_o stays 0 until reset.
- R10: If retrace_i rises during the measurement lines, meas_en_o and ref_win_o drop to 0 the clock after. The sequence restarts only after that retrace ends.
- R11: A line_start_i pulse sampled while retrace_i is high does not start the sequence. A line_start_i pulse with no retrace since the last completed sequence also does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-clock pulse at the start of each line |
| retrace_i | input | 1 | High during field retrace |
| beam_det_i | input | 1 | Cathode current detected |
| leak_smp_o | output | 1 | Leakage sample-and-hold enable |
| meas_en_o | output | NUM_CH | Per-channel cut-off measurement enable, bit 0 red |
| ref_win_o | output | 1 | Reference-line insertion window |
| white_req_o | output | 1 | White insertion request during warm-up |

## Verification
The bench builds the block with its default of three channels. This covers the full red, green, blue order and the clear on the fourth line. Short lines of a few clocks let many fields, an aborted sequence and the warm-up exit all fit within a short run. Line starts during retrace and with no retrace since the last sequence are driven to show they do not start a sequence.

// File: rtl/cutoff_pkg.sv
package cutoff_pkg;
  localparam int unsigned CH_DEFAULT = 3;
  typedef enum logic {WARM_UP = 1'b0, LOOPS_ON = 1'b1} loop_state_e;
endpackage

// File: rtl/cutoff_warmup.sv
module cutoff_warmup
  import cutoff_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beam_det_i,
  output logic loop_on_o
);
  loop_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             state_q <= WARM_UP;
    else if (state_q == WARM_UP && beam_det_i) state_q <= LOOPS_ON;
  end

  assign loop_on_o = (state_q == LOOPS_ON);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(loop_on_o) |-> loop_on_o);
  assert_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loop_on_o) |-> $past(beam_det_i));
endmodule

// File: rtl/cutoff_line_seq.sv
module cutoff_line_seq #(
  parameter int unsigned NUM_CH = 3,
  localparam int unsigned IW = $clog2(NUM_CH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_start_i,
  input  logic          retrace_i,
  output logic [IW-1:0] line_idx_o,
  output logic          leak_o
);
  logic          armed_q, leak_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
      leak_q  <= 1'b0;
    end else begin
      leak_q <= retrace_i;
      if (retrace_i) begin
        armed_q <= 1'b1;
        idx_q   <= '0;
      end else if (line_start_i) begin
        if (armed_q) begin
          armed_q <= 1'b0;
          idx_q   <= IW'(1);
        end else if (idx_q == IW'(NUM_CH)) begin
          idx_q <= '0;
        end else if (idx_q != '0) begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  assign line_idx_o = idx_q;
  assign leak_o     = leak_q;

  assert_idx_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IW'(NUM_CH));
  assert_leak_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leak_q |-> idx_q == '0);
  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retrace_i |=> idx_q == '0);
  assert_no_start_in_retrace_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idx_q != '0) |-> $past(line_start_i) && !$past(retrace_i));
endmodule

// File: rtl/cutoff_seq.sv
module cutoff_seq
  import cutoff_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_DEFAULT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              retrace_i,
  input  logic              beam_det_i,
  output logic              leak_smp_o,
  output logic [NUM_CH-1:0] meas_en_o,
  output logic              ref_win_o,
  output logic              white_req_o
);
  localparam int unsigned IW = $clog2(NUM_CH + 1);

  logic          loop_on, leak_raw;
  logic [IW-1:0] line_idx;

  cutoff_warmup u_warmup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beam_det_i (beam_det_i),
    .loop_on_o  (loop_on)
  );

  cutoff_line_seq #(.NUM_CH(NUM_CH)) u_line_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .retrace_i    (retrace_i),
    .line_idx_o   (line_idx),
    .leak_o       (leak_raw)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign meas_en_o[c] = loop_on && (line_idx == IW'(c + 1));
    if (c > 0) begin : g_order
      assert_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(meas_en_o[c]) && $past(loop_on) |-> $past(meas_en_o[c-1]));
    end
  end

  assign ref_win_o   = loop_on && (line_idx != '0);
  assign leak_smp_o  = loop_on && leak_raw;
  assign white_req_o = !loop_on;

  assert_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(meas_en_o) && !(leak_smp_o && meas_en_o != '0));
  assert_full_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(line_start_i) && !$past(retrace_i) && $past(loop_on) |-> $stable(meas_en_o));
  assert_warmup_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    white_req_o |-> !leak_smp_o && !ref_win_o && meas_en_o == '0);
  assert_ref_win_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_win_o == (meas_en_o != '0));
endmodule

// File: tb/tb_cutoff_seq.sv
module tb_cutoff_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_start = 1'b0, retrace = 1'b0, beam = 1'b0;
  logic leak, ref_win, white;
  logic [NCH-1:0] meas;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cutoff_seq #(.NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .retrace_i(retrace),
    .beam_det_i(beam), .leak_smp_o(leak), .meas_en_o(meas), .ref_win_o(ref_win),
    .white_req_o(white)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one line: pulse, then check both right after and late in the line
  task automatic line(input string req, input int exp_meas, input int exp_ref);
    line_start = 1'b1; cyc(1); line_start = 1'b0;
    chk(req, meas, exp_meas); chk({req, " ref R6"}, ref_win, exp_ref);
    cyc(4);
    chk({req, " full line R3"}, meas, exp_meas);
  endtask

  task automatic do_retrace(input int lines, input int exp_leak);
    retrace = 1'b1; cyc(1);
    chk("R2 leak during retrace", leak, exp_leak);
    for (int l = 0; l < lines; l++) line("R11 start in retrace", 0, 0);
    retrace = 1'b0; cyc(1);
    chk("R2 leak after retrace", leak, 0);
  endtask

  task automatic t_reset;
    cyc(1);
    chk("R1 white", white, 1); chk("R1 meas", meas, 0);
    chk("R1 leak", leak, 0);   chk("R1 ref", ref_win, 0);
    rst_n = 1'b1; cyc(1);
    chk("R1 white after reset", white, 1);
  endtask

  task automatic t_warmup_field;
    do_retrace(2, 0);
    line("R7 warm-up line1", 0, 0);
    line("R7 warm-up line2", 0, 0);
    chk("R7 white held", white, 1);
  endtask

  task automatic t_exit;
    beam = 1'b1; cyc(1); beam = 1'b0;
    chk("R8 white falls", white, 0);
  endtask

  task automatic t_field;
    do_retrace(2, 1);
    cyc(2); chk("R3 idle before line1", meas, 0);
    line("R3 red line", 1, 1);
    line("R4 green line", 2, 1);
    line("R4 blue line", 4, 1);
    line("R4 cleared", 0, 0);
    line("R11 no retrace", 0, 0);
    chk("R9 white stays low", white, 0);
  endtask

  task automatic t_abort;
    do_retrace(1, 1);
    line("R3 red before abort", 1, 1);
    retrace = 1'b1; cyc(1);
    chk("R10 abort meas", meas, 0); chk("R10 abort ref", ref_win, 0);
    retrace = 1'b0; cyc(1);
    line("R10 restart red", 1, 1);
    line("R10 restart green", 2, 1);
    line("R10 restart blue", 4, 1);
    line("R10 restart clear", 0, 0);
  endtask

  initial begin
    t_reset();
    t_warmup_field();
    t_exit();
    t_field();
    beam = 1'b1; t_field(); beam = 1'b0;
    t_field();
    t_abort();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        cyc(20000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule